// File: doc/BRIEF.md
# Triple-Buffered Frame Address Sequencer

This block generates write and read addresses for three frame buffers in external memory, shared by a slow camera writer and a fast display reader in unrelated clock domains. The writer side counts accepted pixels into a linear address inside the buffer it currently owns. The reader side produces linear addresses inside the buffer it currently shows. These read addresses are cropped vertically to a window of the stored frame.

A finished frame is handed to the reader domain with a toggle handshake. The reader echoes the toggle back together with the index of the buffer it holds. Until that echo returns, the writer accepts no pixels. The writer then moves to the one buffer that is neither the newest frame nor the reader's buffer. The reader changes buffer only at its own frame start. At that point it takes the newest completed frame if one has arrived since its last switch. Otherwise it shows its current buffer again. Because of these rules, a displayed frame is never torn and never partly written.

Top module: `frame_triple_buf`

## Requirements
- R1: After reset the writer owns buffer 0 and the reader owns buffer 1. With no pixel strobe, `w_addr` equals the buffer 0 base. `r_addr` equals the buffer 1 base plus `H_PIX*TOP_LINE`.
- R2: Buffer index i (0, 1 or 2) has the base address `BASE_OFS + i*H_PIX*V_LINES`.
- R3: `w_addr` equals the base of `w_buf` plus the number of pixels accepted since the last `w_sof` or the last completed frame. `w_we` is high when `w_valid` is high, `w_sof` is low and no handoff is pending.
- R4: A frame is complete only when `H_PIX*V_LINES` pixels have been accepted. A `w_sof` before that count restarts the frame in the same buffer, and no handoff takes place. The reader therefore stays on its buffer.
- R5: Once a frame completes, `w_we` stays low even while `w_valid` is high, until the reader has acknowledged the handoff. The writer then owns the buffer that is neither the newest frame nor the acknowledged reader buffer. For the first frame this is buffer 2.
- R6: `r_addr` equals the base of `r_buf` plus `H_PIX*TOP_LINE` plus k, where k counts `r_read` strobes since `r_sof`. k wraps to 0 after `H_PIX*(END_LINE-TOP_LINE)` reads.
- R7: `r_buf` changes only on the clock edge at which `r_sof` is high.
- R8: At a reader frame start the reader takes the newest completed frame if it is newer than the one shown. Otherwise it repeats its buffer. Displayed frame numbers never decrease, and once the writer stops, the newest frame is displayed.
- R9: The buffer receiving a pixel is never `r_buf`. Every displayed frame comes entirely from one fully written frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Writer (camera) clock |
| wrst_n | input | 1 | Writer domain reset, active low |
| w_sof | input | 1 | Writer frame-start pulse |
| w_valid | input | 1 | Pixel-valid strobe |
| w_we | output | 1 | Pixel accepted, write at `w_addr` |
| w_addr | output | AW | Linear write address |
| w_buf | output | 2 | Buffer owned by the writer |
| rclk | input | 1 | Reader (display) clock |
| rrst_n | input | 1 | Reader domain reset, active low |
| r_sof | input | 1 | Reader frame-start pulse |
| r_read | input | 1 | Pixel-read strobe, advances `r_addr` |
| r_addr | output | AW | Linear read address, cropped window |
| r_buf | output | 2 | Buffer shown by the reader |

## Verification
If the buffer index state goes wrong, the write and read addresses land in one buffer. The reader then fetches pixels tagged with an unfinished or older frame, or it fetches pixels with mixed tags, within the same display frame. A lost or duplicated handoff toggle shows up in one of two ways. Either `w_we` stays low for good, so the next frame is refused, or the display stops advancing to newer frames. A wrong pixel counter moves `w_addr` or `r_addr` off the expected offset at the very next strobe.

// File: rtl/frame_triple_buf.sv
module frame_triple_buf #(
  parameter int H_PIX    = 640,
  parameter int V_LINES  = 512,
  parameter int TOP_LINE = 16,
  parameter int END_LINE = 496,
  parameter int AW       = 22,
  parameter int BASE_OFS = 0
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          w_sof,
  input  logic          w_valid,
  output logic          w_we,
  output logic [AW-1:0] w_addr,
  output logic [1:0]    w_buf,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          r_sof,
  input  logic          r_read,
  output logic [AW-1:0] r_addr,
  output logic [1:0]    r_buf
);
  localparam int FRAME = H_PIX * V_LINES;
  localparam int VIS   = H_PIX * (END_LINE - TOP_LINE);
  localparam int CROP  = H_PIX * TOP_LINE;
  localparam int CW    = $clog2(FRAME + 1);
  localparam int RW    = $clog2(VIS + 1);

  function automatic logic [AW-1:0] base_of(input logic [1:0] idx);
    return AW'(BASE_OFS) + AW'(idx) * AW'(FRAME);
  endfunction

  // writer domain
  logic [1:0]    w_idx, w_done_idx;
  logic [CW-1:0] w_cnt;
  logic          w_done_tgl, w_wait;
  logic          ack_s1, ack_s2;
  // reader domain
  logic [1:0]    r_idx, r_latest, r_ack_idx;
  logic [RW-1:0] r_cnt;
  logic          r_pend, r_ack_tgl;
  logic          dn_s1, dn_s2, dn_s3;

  assign w_we   = w_valid & ~w_sof & ~w_wait;
  assign w_addr = base_of(w_idx) + AW'(w_cnt);
  assign w_buf  = w_idx;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= r_ack_tgl;
      ack_s2 <= ack_s1;
    end
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      w_idx      <= 2'd0;
      w_done_idx <= 2'd0;
      w_cnt      <= '0;
      w_done_tgl <= 1'b0;
      w_wait     <= 1'b0;
    end else if (w_wait) begin
      if (ack_s2 == w_done_tgl) begin
        w_wait <= 1'b0;
        w_idx  <= 2'd3 - w_done_idx - r_ack_idx;
      end
    end else if (w_sof) begin
      w_cnt <= '0;
    end else if (w_valid) begin
      if (w_cnt == CW'(FRAME - 1)) begin
        w_done_idx <= w_idx;
        w_done_tgl <= ~w_done_tgl;
        w_wait     <= 1'b1;
        w_cnt      <= '0;
      end else begin
        w_cnt <= w_cnt + 1'b1;
      end
    end
  end

  assign r_addr = base_of(r_idx) + AW'(CROP) + AW'(r_cnt);
  assign r_buf  = r_idx;

  wire dn_new = dn_s2 ^ dn_s3;
  wire r_swap = r_sof & r_pend;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      dn_s1 <= 1'b0;
      dn_s2 <= 1'b0;
      dn_s3 <= 1'b0;
    end else begin
      dn_s1 <= w_done_tgl;
      dn_s2 <= dn_s1;
      dn_s3 <= dn_s2;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      r_idx     <= 2'd1;
      r_latest  <= 2'd0;
      r_ack_idx <= 2'd1;
      r_pend    <= 1'b0;
      r_ack_tgl <= 1'b0;
    end else begin
      if (r_swap) r_idx <= r_latest;
      if (dn_new) begin
        r_latest  <= w_done_idx;
        r_pend    <= 1'b1;
        r_ack_tgl <= dn_s2;
        r_ack_idx <= r_swap ? r_latest : r_idx;
      end else if (r_swap) begin
        r_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) r_cnt <= '0;
    else if (r_sof) r_cnt <= '0;
    else if (r_read) r_cnt <= (r_cnt == RW'(VIS - 1)) ? '0 : r_cnt + 1'b1;
  end

  // R2
  w_idx_range_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    w_idx != 2'd3);

  // R4
  done_after_full_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (w_done_tgl != $past(w_done_tgl)) |-> ($past(w_cnt) == CW'(FRAME - 1) && $past(w_valid)));

  // R5
  w_idx_hold_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    !$past(w_wait) |-> $stable(w_idx));

  // R6
  r_cnt_bound_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    r_cnt < RW'(VIS));

  // R7
  r_swap_at_sof_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (r_idx != $past(r_idx)) |-> $past(r_sof));
endmodule

// File: tb/frame_triple_buf_tb_top.sv
module frame_triple_buf_tb_top;
  localparam int H = 4, V = 6, TOP = 1, ENDL = 5, AW = 8, OFS = 5;
  localparam int FRAME = H * V;
  localparam int VIS = H * (ENDL - TOP);
  localparam int CROP = H * TOP;
  localparam int NFR = 12;

  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic w_sof = 0, w_valid = 0, r_sof = 0, r_read = 0;
  logic w_we;
  logic [AW-1:0] w_addr, r_addr;
  logic [1:0] w_buf, r_buf;

  frame_triple_buf #(.H_PIX(H), .V_LINES(V), .TOP_LINE(TOP), .END_LINE(ENDL),
                     .AW(AW), .BASE_OFS(OFS)) dut_i (
    .wclk(wclk), .wrst_n(wrst_n), .w_sof(w_sof), .w_valid(w_valid),
    .w_we(w_we), .w_addr(w_addr), .w_buf(w_buf),
    .rclk(rclk), .rrst_n(rrst_n), .r_sof(r_sof), .r_read(r_read),
    .r_addr(r_addr), .r_buf(r_buf));

  always #2.5 wclk = ~wclk;
  always #1.55 rclk = ~rclk;

  int nchk = 0, nerr = 0;
  int mem [0:3*FRAME+OFS-1];
  int wdone = 0, last_fn = -1, repeats = 0;
  bit shown = 0, stop_rd = 0, done_all = 0;
  logic sof_edge = 0;
  logic [1:0] prev_rbuf = 2'd1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wframe(input int npix, input int tag);
    int acc = 0;
    @(negedge wclk); w_sof = 1;
    @(negedge wclk); w_sof = 0;
    for (int i = 0; i < npix; i++) begin
      w_valid = 1; #1;
      chk(w_we == 1, "R3 we", w_we, 1);
      chk(int'(w_addr) == OFS + int'(w_buf) * FRAME + acc, "R3 addr", w_addr, OFS + int'(w_buf) * FRAME + acc);
      chk(w_buf != r_buf, "R9 owner", w_buf, r_buf);
      if (w_we) begin
        mem[w_addr] = tag * 1000 + acc;
        acc++;
      end
      @(negedge wclk); w_valid = 0;
      if (i % 3 == 1) @(negedge wclk);
    end
  endtask

  // R7: buffer change only on an r_sof edge
  always @(posedge rclk) sof_edge <= r_sof;
  always @(negedge rclk) if (rrst_n) begin
    if (r_buf != prev_rbuf) chk(sof_edge == 1, "R7 switch", r_buf, prev_rbuf);
    prev_rbuf = r_buf;
  end

  task automatic rframe();
    int fn = -2;
    @(negedge rclk); r_sof = 1;
    @(negedge rclk); r_sof = 0;
    if (r_buf != 2'd1) shown = 1;
    for (int k = 0; k < VIS; k++) begin
      int off, t;
      r_read = 1; #1;
      off = int'(r_addr) - OFS;
      chk(off / FRAME == int'(r_buf) && off % FRAME == CROP + k, "R6 raddr", off, int'(r_buf) * FRAME + CROP + k);
      t = mem[r_addr];
      if (!shown) chk(t == -1 && wdone == 0 || t == -1, "R4 stay", t, -1);
      else begin
        if (k == 0) begin
          fn = t / 1000;
          chk(fn >= last_fn, "R8 order", fn, last_fn);
          chk(fn < wdone && t >= 0, "R9 complete", fn, wdone - 1);
          if (fn == last_fn) repeats++;
          last_fn = fn;
        end
        chk(t == fn * 1000 + CROP + k, "R9 whole", t, fn * 1000 + CROP + k);
      end
      @(negedge rclk); r_read = 0;
    end
    repeat (4) @(negedge rclk);
  endtask

  initial begin
    for (int i = 0; i < 3 * FRAME + OFS; i++) mem[i] = -1;
    #12 wrst_n = 1; rrst_n = 1;
    @(negedge wclk); #1;
    // R1 / R2
    chk(w_buf == 0 && int'(w_addr) == OFS, "R1 w", w_addr, OFS);
    chk(r_buf == 1 && int'(r_addr) == OFS + FRAME + CROP, "R1 r", r_addr, OFS + FRAME + CROP);
    fork
      begin
        while (!stop_rd) rframe();
      end
      begin
        wframe(10, 999);               // R4 aborted frame
        repeat (60) @(negedge wclk);
        chk(r_buf == 1, "R4 no handoff", r_buf, 1);
        for (int f = 0; f < NFR; f++) begin
          wframe(FRAME, f);
          wdone++;
          if (f == 0) begin
            @(negedge wclk); w_valid = 1; #1;
            chk(w_we == 0, "R5 hold", w_we, 0);
            @(negedge wclk); w_valid = 0;
            repeat (40) @(negedge wclk);
            chk(w_buf == 2, "R5 first next", w_buf, 2);
          end else repeat (40) @(negedge wclk);
        end
        repeat (200) @(negedge wclk);
        stop_rd = 1;
      end
    join
    rframe();
    chk(last_fn == NFR - 1, "R8 newest", last_fn, NFR - 1);
    chk(repeats > 0, "R8 repeat", repeats, 1);
    done_all = 1;
  end

  initial begin
    fork
      wait (done_all);
      begin #200000; chk(0, "watchdog", 0, 1); end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule